// File: doc/BRIEF.md
# Phase-Two Bus Slave Register Block

This block is the register front end of a peripheral that sits on an 8-bit microprocessor bus. The bus uses a single phase clock (phi2), a read/write line and an external chip select. A fast system clock oversamples every bus signal. The block holds four byte-wide registers: a general data register, a control register, an interrupt status register that clears when read, and an interrupt enable register. It drives the read data with an output enable, an active-low interrupt request, and a pair of active-low read and write strobes for an attached device.

The block is built for shared-bus systems, where a second master owns the bus while phi2 is low. In those systems the address can still be settling after phi2 rises. The block therefore never takes the address at the rising edge. Every write and every read side effect is committed once, at the detected falling edge of phi2. The address, data, direction and select used for that commit are the ones sampled in the last system clock cycle in which phi2 was still high.

Top module: `bus6502_regif`

## Requirements
- R1: After reset all four registers hold 0, `irq_n_o` is 1, `data_oe_o` is 0, `data_o` is 0, and both `rd_n_o` and `wr_n_o` are 1.
- R2: `data_oe_o` is 1 only while the synchronized phi2 is high, the synchronized chip select is active (low) and the synchronized R/W is high (read). It follows a chip select that arrives late in phi2 high. `data_o` is 0 whenever `data_oe_o` is 0.
- R3: During a selected read, `data_o` shows the register picked by `addr_i`: 0 is data, 1 is control, 2 is interrupt status, 3 is interrupt enable. Reading data, control or enable changes nothing.
- R4: A selected write (R/W low) stores `data_i` into the register at `addr_i` two system clocks after phi2 is sampled low. The stored value is the one present on the last sample with phi2 high. Writes to address 2 are ignored.
- R5: A selected read of address 2 clears the interrupt status at the phi2 falling edge. Only the address present at the end of phi2 high counts. An address of 2 seen only early in phi2 high clears nothing.
- R6: Each bit set in `event_i` on a clock edge sets the matching status bit, which then stays set until it is cleared by a read.
- R7: When an event bit and a read-clear of the status land on the same clock edge, that status bit stays set, and the other bits clear.
- R8: `irq_n_o` is 0 exactly when the bitwise AND of status and enable is nonzero.
- R9: `wr_n_o` is 0 only while synchronized phi2 is high, R/W is low and chip select is active. `rd_n_o` is 0 only while synchronized phi2 is high, R/W is high and chip select is active. The two are never low at the same time.
- R10: While phi2 is low, or for a bus cycle whose chip select is inactive, no register changes, no strobe goes low and the data output stays disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than phi2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2_i | input | 1 | Bus phase clock; high marks the active half of a bus cycle |
| rw_i | input | 1 | Bus direction: 1 read, 0 write |
| cs_n_i | input | 1 | Active-low chip select from external decoding |
| addr_i | input | 2 | Register address |
| data_i | input | 8 | Bus data in |
| event_i | input | 8 | Per-bit interrupt event pulses |
| data_o | output | 8 | Read data toward the bus |
| data_oe_o | output | 1 | Bus data output enable |
| irq_n_o | output | 1 | Active-low interrupt request |
| rd_n_o | output | 1 | Active-low read strobe for the attached device |
| wr_n_o | output | 1 | Active-low write strobe for the attached device |

## Verification
Bus inputs pass through two synchronizer flops. So `data_oe_o`, `data_o` and the strobes respond on the second system clock edge after an input change. A register commit lands on the second edge after phi2 is sampled low, and `irq_n_o` follows the new register contents at that same edge. The bench drives inputs on falling clock edges. It samples the read outputs five cycles into phi2 high. Status and interrupt checks happen only four or more cycles after phi2 falls, so every commit has settled. The R7 event is placed in the single cycle that ends on the commit edge. The late-select and early-address cases step the inputs in the middle of phi2 high and check the outputs after the two-edge delay.

// File: rtl/regif_pkg.sv
package regif_pkg;

    localparam int unsigned REGIF_ADDR_W = 2;

    typedef enum logic [REGIF_ADDR_W-1:0] {
        SEL_DAT = 2'd0,
        SEL_CTL = 2'd1,
        SEL_STS = 2'd2,
        SEL_IEN = 2'd3
    } regif_sel_e;

endpackage

// File: rtl/regif_sync.sv
module regif_sync #(
    parameter int unsigned WIDTH   = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[g] <= RST_VAL;
            end else begin
                stage_q[g] <= stage_d[g];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/regif_regs.sv
module regif_regs
    import regif_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_wr,
    input  logic                    commit_rd,
    input  logic [REGIF_ADDR_W-1:0] commit_addr,
    input  logic [DATA_W-1:0]       commit_data,
    input  logic [DATA_W-1:0]       event_i,
    output logic [DATA_W-1:0]       dat_q,
    output logic [DATA_W-1:0]       ctl_q,
    output logic [DATA_W-1:0]       sts_q,
    output logic [DATA_W-1:0]       ien_q
);
    typedef struct packed {
        logic [DATA_W-1:0] dat;
        logic [DATA_W-1:0] ctl;
        logic [DATA_W-1:0] sts;
        logic [DATA_W-1:0] ien;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (commit_wr) begin
            unique case (regif_sel_e'(commit_addr))
                SEL_DAT: r_d.dat = commit_data;
                SEL_CTL: r_d.ctl = commit_data;
                SEL_STS: r_d.sts = r_q.sts;
                SEL_IEN: r_d.ien = commit_data;
                default: r_d = r_q;
            endcase
        end
        if (commit_rd && regif_sel_e'(commit_addr) == SEL_STS) begin
            r_d.sts = '0;
        end
        // a fresh event beats a clear on the same edge
        r_d.sts = r_d.sts | event_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dat_q = r_q.dat;
    assign ctl_q = r_q.ctl;
    assign sts_q = r_q.sts;
    assign ien_q = r_q.ien;
endmodule

// File: rtl/bus6502_regif.sv
module bus6502_regif
    import regif_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    phi2_i,
    input  logic                    rw_i,
    input  logic                    cs_n_i,
    input  logic [REGIF_ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0]       data_i,
    input  logic [DATA_W-1:0]       event_i,
    output logic [DATA_W-1:0]       data_o,
    output logic                    data_oe_o,
    output logic                    irq_n_o,
    output logic                    rd_n_o,
    output logic                    wr_n_o
);
    localparam int unsigned CTRL_W = 3;
    localparam int unsigned PAY_W  = REGIF_ADDR_W + DATA_W;

    typedef struct packed {
        logic                    phi2_prev;
        logic                    rw;
        logic                    cs;
        logic [REGIF_ADDR_W-1:0] addr;
        logic [DATA_W-1:0]       data;
    } hold_t;

    logic [CTRL_W-1:0] ctrl_s;
    logic [PAY_W-1:0]  pay_s;
    logic              phi2_s, rw_s, cs_s;
    logic [REGIF_ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0]       wdata_s;

    // phi2, R/W and select: metastability synchronizers
    regif_sync #(
        .WIDTH(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)
    ) u_sync_ctrl (
        .clk(clk), .rst_n(rst_n),
        .d({phi2_i, rw_i, cs_n_i}), .q(ctrl_s)
    );

    // address and data: delay matched to the control path
    regif_sync #(
        .WIDTH(PAY_W), .STAGES(SYNC_STAGES), .RST_VAL('0)
    ) u_sync_pay (
        .clk(clk), .rst_n(rst_n),
        .d({addr_i, data_i}), .q(pay_s)
    );

    assign phi2_s  = ctrl_s[2];
    assign rw_s    = ctrl_s[1];
    assign cs_s    = ~ctrl_s[0];
    assign addr_s  = pay_s[PAY_W-1 -: REGIF_ADDR_W];
    assign wdata_s = pay_s[DATA_W-1:0];

    hold_t h_d, h_q;
    logic  fall, commit_wr, commit_rd, read_sel;
    logic [DATA_W-1:0] dat_q, ctl_q, sts_q, ien_q;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        h_d           = h_q;
        h_d.phi2_prev = phi2_s;
        if (phi2_s) begin
            h_d.rw   = rw_s;
            h_d.cs   = cs_s;
            h_d.addr = addr_s;
            h_d.data = wdata_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '{phi2_prev: 1'b0, rw: 1'b1, cs: 1'b0, addr: '0, data: '0};
        end else begin
            h_q <= h_d;
        end
    end

    assign fall      = h_q.phi2_prev & ~phi2_s;
    assign commit_wr = fall & h_q.cs & ~h_q.rw;
    assign commit_rd = fall & h_q.cs &  h_q.rw;

    regif_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .commit_wr(commit_wr), .commit_rd(commit_rd),
        .commit_addr(h_q.addr), .commit_data(h_q.data),
        .event_i(event_i),
        .dat_q(dat_q), .ctl_q(ctl_q), .sts_q(sts_q), .ien_q(ien_q)
    );

    always_comb begin
        unique case (regif_sel_e'(addr_s))
            SEL_DAT: rd_mux = dat_q;
            SEL_CTL: rd_mux = ctl_q;
            SEL_STS: rd_mux = sts_q;
            SEL_IEN: rd_mux = ien_q;
            default: rd_mux = '0;
        endcase
    end

    assign read_sel  = phi2_s & cs_s & rw_s;
    assign data_oe_o = read_sel;
    assign data_o    = read_sel ? rd_mux : '0;
    assign rd_n_o    = ~read_sel;
    assign wr_n_o    = ~(phi2_s & cs_s & ~rw_s);
    assign irq_n_o   = ~|(sts_q & ien_q);
endmodule

// File: rtl/bus6502_regif_chk.sv
module bus6502_regif_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              phi2_i,
    input logic              rw_i,
    input logic              cs_n_i,
    input logic [DATA_W-1:0] event_i,
    input logic [DATA_W-1:0] data_o,
    input logic              data_oe_o,
    input logic              wr_n_o,
    input logic              fall,
    input logic [DATA_W-1:0] dat_q,
    input logic [DATA_W-1:0] ctl_q,
    input logic [DATA_W-1:0] sts_q,
    input logic [DATA_W-1:0] ien_q
);
    // R2
    oe_needs_read_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> ($past(phi2_i, 2) && !$past(cs_n_i, 2) && $past(rw_i, 2)));

    // R2
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe_o |-> (data_o == '0));

    // R9
    wr_strobe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> ($past(phi2_i, 2) && !$past(cs_n_i, 2) && !$past(rw_i, 2)));

    // R10
    regs_hold_off_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> ($stable(dat_q) && $stable(ctl_q) && $stable(ien_q)));

    // R6
    event_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_i) |=> ((sts_q & $past(event_i)) == $past(event_i)));
endmodule

bind bus6502_regif bus6502_regif_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .phi2_i(phi2_i), .rw_i(rw_i), .cs_n_i(cs_n_i),
    .event_i(event_i), .data_o(data_o), .data_oe_o(data_oe_o), .wr_n_o(wr_n_o),
    .fall(fall), .dat_q(dat_q), .ctl_q(ctl_q), .sts_q(sts_q), .ien_q(ien_q)
);

// File: tb/bus6502_regif_test.sv
module bus6502_regif_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phi2 = 1'b0, rw = 1'b1, cs_n = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0, ev = '0;
    logic [7:0] data_o;
    logic       data_oe_o, irq_n_o, rd_n_o, wr_n_o;

    int n_chk = 0, n_fail = 0;
    logic [7:0] s_rd;
    logic       s_oe, s_rdn, s_wrn;

    always #2 clk = ~clk;

    bus6502_regif uut (
        .clk(clk), .rst_n(rst_n), .phi2_i(phi2), .rw_i(rw), .cs_n_i(cs_n),
        .addr_i(addr), .data_i(wdata), .event_i(ev),
        .data_o(data_o), .data_oe_o(data_oe_o), .irq_n_o(irq_n_o),
        .rd_n_o(rd_n_o), .wr_n_o(wr_n_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one bus cycle; ev_m is applied in the cycle ending on the commit edge
    task automatic bus(input logic sel, input logic r, input logic [1:0] a,
                       input logic [7:0] d, input logic [7:0] ev_m);
        @(negedge clk);
        cs_n = ~sel; rw = r; addr = a; wdata = d; phi2 = 1'b1;
        repeat (5) @(negedge clk);
        s_rd = data_o; s_oe = data_oe_o; s_rdn = rd_n_o; s_wrn = wr_n_o;
        phi2 = 1'b0;
        @(negedge clk);
        @(negedge clk); ev = ev_m;
        @(negedge clk); ev = '0; cs_n = 1'b1; rw = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
        bus(1'b1, 1'b1, a, 8'h00, 8'h00);
        v = s_rd;
    endtask

    task automatic set_events(input logic [7:0] m);
        @(negedge clk); ev = m;
        @(negedge clk); ev = '0;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 irq_n", irq_n_o, 1);
        chk("R1 oe", data_oe_o, 0);
        chk("R1 data_o", data_o, 0);
        chk("R1 rd_n", rd_n_o, 1);
        chk("R1 wr_n", wr_n_o, 1);
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), v);
            chk("R1 reg zero", v, 0);
        end

        // R4 R3 sweep of the data register
        for (int x = 0; x < 256; x++) begin
            bus(1'b1, 1'b0, 2'd0, 8'(x), 8'h00);
            chk("R9 wr_n low in write", s_wrn, 0);
            chk("R9 rd_n high in write", s_rdn, 1);
            chk("R2 no oe in write", s_oe, 0);
            rd_reg(2'd0, v);
            chk("R3 data readback", v, x);
            chk("R2 oe in read", s_oe, 1);
            chk("R9 rd_n low in read", s_rdn, 0);
            chk("R9 wr_n high in read", s_wrn, 1);
        end

        // R4 control and enable, status write ignored
        bus(1'b1, 1'b0, 2'd1, 8'h3C, 8'h00);
        bus(1'b1, 1'b0, 2'd3, 8'hC3, 8'h00);
        bus(1'b1, 1'b0, 2'd2, 8'hFF, 8'h00);
        rd_reg(2'd1, v); chk("R4 control", v, 8'h3C);
        rd_reg(2'd3, v); chk("R4 enable", v, 8'hC3);
        rd_reg(2'd2, v); chk("R4 status write ignored", v, 0);
        chk("R8 irq off", irq_n_o, 1);
        rd_reg(2'd0, v); chk("R3 data untouched", v, 8'hFF);
        rd_reg(2'd1, v); chk("R3 control read no side effect", v, 8'h3C);

        // R10 idle phi2 low with select and write
        @(negedge clk); cs_n = 1'b0; rw = 1'b0; addr = 2'd0; wdata = 8'h55;
        repeat (8) @(negedge clk);
        chk("R10 wr_n idle", wr_n_o, 1);
        chk("R10 oe idle", data_oe_o, 0);
        cs_n = 1'b1; rw = 1'b1;
        rd_reg(2'd0, v); chk("R10 phi2 low no write", v, 8'hFF);
        // R10 unselected write cycle
        bus(1'b0, 1'b0, 2'd0, 8'h12, 8'h00);
        chk("R10 wr_n unselected", s_wrn, 1);
        rd_reg(2'd0, v); chk("R10 unselected no write", v, 8'hFF);
        bus(1'b0, 1'b1, 2'd1, 8'h00, 8'h00);
        chk("R10 oe unselected", s_oe, 0);

        // R2 late chip select
        @(negedge clk); phi2 = 1'b1; rw = 1'b1; addr = 2'd1; cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 oe before select", data_oe_o, 0);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 oe after late select", data_oe_o, 1);
        chk("R3 data after late select", data_o, 8'h3C);
        phi2 = 1'b0;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 oe after phi2 low", data_oe_o, 0);

        // R6 R8 sweep of enable against fixed status
        set_events(8'h5A);
        for (int e = 0; e < 256; e++) begin
            bus(1'b1, 1'b0, 2'd3, 8'(e), 8'h00);
            chk("R8 irq vs enable", irq_n_o, ((e & 8'h5A) != 0) ? 0 : 1);
        end
        rd_reg(2'd2, v); chk("R6 sticky status", v, 8'h5A);
        rd_reg(2'd2, v); chk("R5 status cleared", v, 0);
        chk("R8 irq after clear", irq_n_o, 1);

        // R5 transient early address
        set_events(8'h81);
        @(negedge clk); cs_n = 1'b0; rw = 1'b1; addr = 2'd2; phi2 = 1'b1;
        repeat (2) @(negedge clk); addr = 2'd0;
        repeat (4) @(negedge clk); phi2 = 1'b0;
        repeat (3) @(negedge clk); cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 early address no clear irq", irq_n_o, 0);
        // late address 2 does clear
        @(negedge clk); cs_n = 1'b0; rw = 1'b1; addr = 2'd0; phi2 = 1'b1;
        repeat (2) @(negedge clk); addr = 2'd2;
        repeat (4) @(negedge clk); phi2 = 1'b0;
        repeat (3) @(negedge clk); cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 late address clears irq", irq_n_o, 1);
        rd_reg(2'd2, v); chk("R5 late address clears status", v, 0);

        // R7 event coincident with clear
        set_events(8'h0F);
        bus(1'b1, 1'b1, 2'd2, 8'h00, 8'h04);
        chk("R7 read value", s_rd, 8'h0F);
        rd_reg(2'd2, v); chk("R7 set wins over clear", v, 8'h04);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule